// File: doc/BRIEF.md
# Bus Slave With Programmable Wait States and Three-Way Termination

This block is a classic-cycle bus slave with a small word-addressed storage array behind it. A beat is in progress when the master holds both the cycle and strobe inputs high. The slave can answer in the first strobed cycle. It can also hold off for a programmed number of wait cycles before it answers. It closes every beat with exactly one of three terminations: acknowledge, error or retry.

Error answers any word address outside the implemented array. Retry comes from a busy input or from a four-entry retry map. The map is indexed by a count of the beats that have closed since reset. Writes that are acknowledged honour the byte-lane selects. Acknowledged reads present the stored word in the same cycle as the acknowledge.

Two named states drive the timing. `ST_IDLE` means no wait is being counted. `ST_WAIT` means the current beat is spending its wait cycles. The transitions are:
- "start wait": `ST_IDLE` to `ST_WAIT`, taken on a strobed cycle when the wait count is nonzero.
- "stay idle": remain in `ST_IDLE` when there is no strobe, or when a zero-wait beat closes.
- "count": remain in `ST_WAIT` while waiting.
- "close": `ST_WAIT` to `ST_IDLE`, taken when the programmed count is reached.
- "abandon": `ST_WAIT` to `ST_IDLE`, taken when the strobe drops.

Top module: `wb_wait_slave`

## Requirements
- R1: In every cycle at most one of `bus_ack`, `bus_err`, `bus_rty` is high.
- R2: A termination is only raised in a cycle where both `bus_cyc` and `bus_stb` are high. If either input is low, all three terminations are low.
- R3: With `wait_cycles` = 0 the slave terminates combinationally in the first strobed cycle of a beat.
- R4: With `wait_cycles` = N > 0, a beat sees N strobed cycles with no termination and is terminated in its (N+1)-th strobed cycle. The cycle before that termination was also strobed.
- R5: When the master keeps the strobe high across back-to-back beats, every beat restarts the wait count and sees the full N wait cycles.
- R6: A word address of `DEPTH` (16) or more ends the beat with `bus_err` and writes nothing. Error takes priority over retry.
- R7: While `busy` is high, an in-range beat ends with `bus_rty` and storage is left unchanged.
- R8: Each termination of any kind advances a beat index from 0 to 3 and then wraps back to 0. The index is 0 after reset. An in-range beat whose `retry_map[index]` bit is 1 ends with `bus_rty`.
- R9: An acknowledged write updates only the byte lanes whose select bit is set. Select bit i covers data bits 8i+7 to 8i.
- R10: An acknowledged read drives the addressed word on `bus_rdata` in the same cycle as `bus_ack`. In every other cycle `bus_rdata` is zero.
- R11: Reset is synchronous and active high. During reset all terminations are low. Reset clears storage to zero, sets the beat index to 0 and returns the FSM to `ST_IDLE`.
- R12: If the strobe drops during wait cycles, the beat is abandoned without a termination. The next strobe starts a fresh full wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_cyc | input | 1 | Cycle in progress |
| bus_stb | input | 1 | Strobe, a beat is requested |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_adr | input | ADDR_W (6) | Word address |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_sel | input | DATA_W/8 (4) | Byte-lane selects |
| busy | input | 1 | Forces retry on in-range beats |
| wait_cycles | input | WAIT_W (4) | Wait cycles inserted before each termination |
| retry_map | input | 2**PAT_W (4) | Retry bit for each beat-index value |
| bus_rdata | output | DATA_W (32) | Read data, valid with acknowledge |
| bus_ack | output | 1 | Normal termination |
| bus_err | output | 1 | Error termination |
| bus_rty | output | 1 | Retry termination |

## Verification
The bench targets several corner cases, each paired with the fault it would expose:
- Zero-wait beats. A slave that registers its answer would terminate one cycle late.
- Blocks with the strobe held high. A counter that fails to restart would answer the second beat with no wait.
- A strobe dropped partway through a wait. A counter that kept running would answer too early on the next strobe.
- An out-of-range write made while busy is high. Getting the priority wrong would show retry instead of error.
- Busy writes and partial-lane writes. Reading these back exposes a slave that writes on a non-acknowledge or ignores the lane selects.
- Retry-map beats. A wrong beat index would retry the wrong beat.

// File: rtl/wbs_pkg.sv
package wbs_pkg;
    typedef enum logic {
        ST_IDLE,
        ST_WAIT
    } wbs_state_e;

    typedef enum logic [1:0] {
        TERM_NONE,
        TERM_ACK,
        TERM_ERR,
        TERM_RTY
    } wbs_term_e;
endpackage

// File: rtl/wbs_timer.sv
module wbs_timer
    import wbs_pkg::*;
#(
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe,
    input  logic [WAIT_W-1:0] wait_cfg,
    output logic              fire
);
    wbs_state_e        st_q, st_d;
    logic [WAIT_W-1:0] cnt_q;

    // state register
    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (strobe && wait_cfg != '0) st_d = ST_WAIT;   // start wait
            ST_WAIT: if (!strobe || cnt_q >= wait_cfg) st_d = ST_IDLE; // abandon / close
            default: st_d = ST_IDLE;
        endcase
    end

    // cycles already spent in the current beat
    always_ff @(posedge clk) begin
        if (rst)                  cnt_q <= '0;
        else if (st_d == ST_WAIT) cnt_q <= cnt_q + 1'b1;
        else                      cnt_q <= '0;
    end

    // output decode
    always_comb begin
        fire = 1'b0;
        if (strobe && !rst) begin
            unique case (st_q)
                ST_IDLE: fire = (wait_cfg == '0);
                ST_WAIT: fire = (cnt_q >= wait_cfg);
                default: fire = 1'b0;
            endcase
        end
    end

    AST_WAIT_HAD_STB: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_WAIT) |-> $past(strobe)); // R4
    AST_WAITED_FIRE_PRIOR: assert property (@(posedge clk) disable iff (rst)
        (fire && wait_cfg != '0) |-> $past(strobe)); // R4
    AST_WAIT_NO_FIRE_LOW: assert property (@(posedge clk) disable iff (rst)
        !strobe |-> !fire); // R12
endmodule

// File: rtl/wbs_decode.sv
module wbs_decode
    import wbs_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DEPTH  = 16,
    parameter int PAT_W  = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                fire,
    input  logic [ADDR_W-1:0]   adr,
    input  logic                busy,
    input  logic [2**PAT_W-1:0] retry_map,
    output wbs_term_e           term
);
    localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(DEPTH);

    logic [PAT_W-1:0] beat_q;
    logic             in_range;

    assign in_range = {1'b0, adr} < LIMIT;

    always_ff @(posedge clk) begin
        if (rst)       beat_q <= '0;
        else if (fire) beat_q <= beat_q + 1'b1;
    end

    always_comb begin
        if (!fire)                        term = TERM_NONE;
        else if (!in_range)               term = TERM_ERR;
        else if (busy || retry_map[beat_q]) term = TERM_RTY;
        else                              term = TERM_ACK;
    end

    AST_ERR_BEATS_RTY: assert property (@(posedge clk) disable iff (rst)
        (fire && !in_range && busy) |-> (term == TERM_ERR)); // R6
endmodule

// File: rtl/wbs_store.sv
module wbs_store #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic                     rd_en,
    input  logic [$clog2(DEPTH)-1:0] idx,
    input  logic [DATA_W-1:0]        wdata,
    input  logic [DATA_W/8-1:0]      sel,
    output logic [DATA_W-1:0]        rdata
);
    localparam int LANES = DATA_W / 8;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] lane_mask;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lane_mask[8*l +: 8] = {8{sel[l]}};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int w = 0; w < DEPTH; w++) mem[w] <= '0;
        end else if (wr_en) begin
            mem[idx] <= (mem[idx] & ~lane_mask) | (wdata & lane_mask);
        end
    end

    assign rdata = rd_en ? mem[idx] : '0;

    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && rd_en)); // R10
endmodule

// File: rtl/wb_wait_slave.sv
module wb_wait_slave
    import wbs_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 6,
    parameter int DEPTH  = 16,
    parameter int WAIT_W = 4,
    parameter int PAT_W  = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_cyc,
    input  logic                bus_stb,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_adr,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic [DATA_W/8-1:0] bus_sel,
    input  logic                busy,
    input  logic [WAIT_W-1:0]   wait_cycles,
    input  logic [2**PAT_W-1:0] retry_map,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                bus_ack,
    output logic                bus_err,
    output logic                bus_rty
);
    localparam int              IDX_W = $clog2(DEPTH);
    localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(DEPTH);

    initial begin
        AST_DATA_WIDTH: assert (DATA_W == 8 || DATA_W == 16 || DATA_W == 32 || DATA_W == 64);
    end

    logic      strobe, fire;
    wbs_term_e term;

    assign strobe = bus_cyc && bus_stb;

    wbs_timer #(.WAIT_W(WAIT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .strobe   (strobe),
        .wait_cfg (wait_cycles),
        .fire     (fire)
    );

    wbs_decode #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .PAT_W(PAT_W)) u_decode (
        .clk       (clk),
        .rst       (rst),
        .fire      (fire),
        .adr       (bus_adr),
        .busy      (busy),
        .retry_map (retry_map),
        .term      (term)
    );

    assign bus_ack = (term == TERM_ACK);
    assign bus_err = (term == TERM_ERR);
    assign bus_rty = (term == TERM_RTY);

    wbs_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .rst   (rst),
        .wr_en (bus_ack && bus_we),
        .rd_en (bus_ack && !bus_we),
        .idx   (bus_adr[IDX_W-1:0]),
        .wdata (bus_wdata),
        .sel   (bus_sel),
        .rdata (bus_rdata)
    );

    AST_RESP_ONEHOT0: assert property (@(posedge clk) disable iff (rst)
        $onehot0({bus_ack, bus_err, bus_rty})); // R1
    AST_TERM_IN_STB: assert property (@(posedge clk) disable iff (rst)
        (bus_ack || bus_err || bus_rty) |-> (bus_cyc && bus_stb)); // R2
    AST_ERR_RANGE: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> ({1'b0, bus_adr} >= LIMIT)); // R6
    AST_BUSY_RTY: assert property (@(posedge clk) disable iff (rst)
        (busy && ({1'b0, bus_adr} < LIMIT)) |-> !bus_ack); // R7
    AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (rst)
        !(bus_ack && !bus_we) |-> (bus_rdata == '0)); // R10
endmodule

// File: tb/wb_wait_slave_tb.sv
module wb_wait_slave_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_cyc = 1'b0, bus_stb = 1'b0, bus_we = 1'b0, busy = 1'b0;
    logic [5:0]  bus_adr = '0;
    logic [31:0] bus_wdata = '0;
    logic [3:0]  bus_sel = '0;
    logic [3:0]  wait_cycles = '0;
    logic [3:0]  retry_map = '0;
    logic [31:0] bus_rdata;
    logic        bus_ack, bus_err, bus_rty;

    always #4 clk = ~clk;   // 125 MHz

    wb_wait_slave u_dut (
        .clk(clk), .rst(rst), .bus_cyc(bus_cyc), .bus_stb(bus_stb), .bus_we(bus_we),
        .bus_adr(bus_adr), .bus_wdata(bus_wdata), .bus_sel(bus_sel), .busy(busy),
        .wait_cycles(wait_cycles), .retry_map(retry_map), .bus_rdata(bus_rdata),
        .bus_ack(bus_ack), .bus_err(bus_err), .bus_rty(bus_rty)
    );

    // behavioural reference state
    int          total = 0, bad = 0;
    int          m_wait = 0, m_beat = 0;
    logic [31:0] m_mem [16];
    bit          last_fire;

    task automatic step(input string tag);
        bit strobe, fire, e_a, e_e, e_r;
        logic [31:0] e_d;
        @(negedge clk);
        strobe = bus_cyc && bus_stb;
        fire = strobe && !rst && (m_wait >= int'(wait_cycles));
        e_a = 0; e_e = 0; e_r = 0; e_d = '0;
        if (fire) begin
            if (bus_adr >= 6'd16)                e_e = 1;
            else if (busy || retry_map[m_beat])  e_r = 1;
            else                                 e_a = 1;
        end
        if (e_a && !bus_we) e_d = m_mem[bus_adr[3:0]];
        total++;
        if (bus_ack !== e_a || bus_err !== e_e || bus_rty !== e_r || bus_rdata !== e_d) begin
            bad++;
            $display("FAIL %s: got ack=%b err=%b rty=%b rdata=%h exp ack=%b err=%b rty=%b rdata=%h",
                     tag, bus_ack, bus_err, bus_rty, bus_rdata, e_a, e_e, e_r, e_d);
        end
        last_fire = fire;
        @(posedge clk);
        #1;
        if (rst) begin
            m_wait = 0; m_beat = 0;
            for (int w = 0; w < 16; w++) m_mem[w] = '0;
        end else if (!strobe) begin
            m_wait = 0;
        end else if (fire) begin
            m_wait = 0;
            m_beat = (m_beat + 1) % 4;
            if (e_a && bus_we)
                for (int l = 0; l < 4; l++)
                    if (bus_sel[l]) m_mem[bus_adr[3:0]][8*l +: 8] = bus_wdata[8*l +: 8];
        end else begin
            m_wait++;
        end
    endtask

    task automatic beat(input bit we, input logic [5:0] adr, input logic [31:0] d,
                        input logic [3:0] sel, input string tag);
        bus_cyc = 1; bus_stb = 1; bus_we = we; bus_adr = adr; bus_wdata = d; bus_sel = sel;
        for (int k = 0; k < 40; k++) begin
            step(tag);
            if (last_fire) break;
        end
    endtask

    task automatic idle(input int n, input string tag);
        bus_cyc = 0; bus_stb = 0;
        for (int k = 0; k < n; k++) step(tag);
    endtask

    initial begin
        #400000;
        bad++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1;
        // R11: reset with strobe high, no termination
        rst = 1; bus_cyc = 1; bus_stb = 1;
        step("R11"); step("R11");
        rst = 0;
        idle(2, "R2");
        beat(0, 6'd0, '0, 4'hF, "R11");          // storage cleared

        // R3 zero wait, R9 full write, R10 readback
        wait_cycles = 0;
        beat(1, 6'd3, 32'hA1B2C3D4, 4'hF, "R3");
        idle(1, "R2");
        beat(0, 6'd3, '0, 4'hF, "R10");
        beat(1, 6'd3, 32'h11223344, 4'b0101, "R9");
        beat(0, 6'd3, '0, 4'hF, "R9");

        // R2 strobe without cycle
        bus_cyc = 0; bus_stb = 1; step("R2"); step("R2");

        // R4 waited, R5 block with strobe held
        wait_cycles = 2;
        idle(1, "R2");
        beat(1, 6'd7, 32'hDEADBEEF, 4'hF, "R4");
        beat(1, 6'd8, 32'hCAFEF00D, 4'b1100, "R5");
        beat(0, 6'd7, '0, 4'hF, "R5");
        beat(0, 6'd8, '0, 4'hF, "R5");
        idle(1, "R2");

        // R12 abandoned wait
        wait_cycles = 3;
        bus_cyc = 1; bus_stb = 1; bus_we = 0; bus_adr = 6'd7;
        step("R12"); step("R12");
        idle(1, "R12");
        beat(0, 6'd7, '0, 4'hF, "R12");
        idle(1, "R2");

        // R6 out of range: error, no write, error beats busy
        wait_cycles = 1;
        beat(1, 6'd20, 32'h55555555, 4'hF, "R6");
        busy = 1;
        beat(1, 6'd63, 32'h66666666, 4'hF, "R6");
        // R7 busy retry, storage unchanged
        beat(1, 6'd5, 32'h77777777, 4'hF, "R7");
        busy = 0;
        beat(0, 6'd4, '0, 4'hF, "R6");
        beat(0, 6'd5, '0, 4'hF, "R7");
        idle(1, "R1");

        // R8 retry map across beat index
        wait_cycles = 0;
        retry_map = 4'b0101;
        for (int i = 0; i < 6; i++) beat(1, 6'(i), 32'h0F0F0000 + i, 4'hF, "R8");
        retry_map = 4'b1010;
        for (int i = 0; i < 5; i++) beat(0, 6'(i), '0, 4'hF, "R8");
        retry_map = '0;
        idle(1, "R1");
        for (int i = 0; i < 6; i++) beat(0, 6'(i), '0, 4'hF, "R10");
        idle(2, "R1");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule